// File: doc/BRIEF.md
# Parallel Port Buffer Enable and Direction Controller

This block sits beside the two parallel I/O groups of a digital I/O interface. Each group has four line buffers: an 8-line port A, an 8-line port B, and the two 4-line halves of port C. The block watches the byte-wide register bus. From every mode word written to a group it derives the direction of that group's four buffers. It also decides, for every buffer, whether the buffer drives its lines or leaves them floating.

Three registers control whether a buffer drives. A two-bit arm register turns the gating on for each group separately. While a group's arm bit is clear, its output-direction buffers always drive. While the bit is set, three kinds of write change which buffers are open. A mode word closes all four buffers. A group-wide open/close write opens or closes all four at once. A bit-mapped per-buffer write opens any subset.

Line values sampled from the pads are passed through unchanged, except on closed buffers. A closed buffer reads as all ones, which is what the board pull-ups produce.

Top module: `pio_buf_ctrl`

## Requirements
- R1: A write to offset 0x3 (group 0) or 0x7 (group 1) sets that group's buffer directions from data bits 4, 3, 1 and 0. These bits go to port A, port C high, port B and port C low, with 1 meaning input. buf_dir_in bit 4*g+3 is port A, bit 4*g+2 is C high, bit 4*g+1 is B and bit 4*g+0 is C low.
- R2: After reset every buffer is an input, no buffer drives, and offsets 0xA, 0xC and 0xD read 0.
- R3: Offset 0xA holds the arm bits. Bit 0 arms group 0 and bit 1 arms group 1. Bits 1:0 read back what was written.
- R4: While a group's arm bit is 0, each of its buffers drives exactly when it is an output. Group-wide and per-buffer writes leave buf_oe for that group unchanged.
- R5: A mode-word write to an armed group closes all four of that group's buffers.
- R6: A write to offset 0x8 (group 0) or 0x9 (group 1) opens all four buffers when data bit 7 is 0 and closes them all when bit 7 is 1. Directions stay unchanged.
- R7: Offset 0xC (group 0) and 0xD (group 1) open individual buffers in an armed group. Bit 3 is port A, bit 2 C high, bit 1 B and bit 0 C low, with 1 meaning open. Bits 3:0 read back what was written.
- R8: An input-direction buffer never drives.
- R9: Every line of a buffer that is armed and closed reads 1 on line_val. All other lines pass pad_in through. Lines 24g+7..24g+0 are port A, 24g+15..24g+8 port B, 24g+19..24g+16 C low and 24g+23..24g+20 C high.
- R10: Offsets other than 0x3, 0x7, 0x8, 0x9, 0xA, 0xC and 0xD read 0. Writes to them change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pad_in | input | 48 | Values sampled on the pads, 24 per group |
| buf_dir_in | output | 8 | Per-buffer direction, 1 = input |
| buf_oe | output | 8 | Per-buffer drive enable |
| line_val | output | 48 | Line values with closed buffers forced high |

## Verification
The bench goes after these corner cases:
- A mode word with bit 7 clear must still close an armed group. A design that opened the buffers here would start driving before the data was ready.
- A group-wide close must leave the directions alone. A design that cleared them would turn inputs into outputs.
- Writes to one group must not reach the other. A decode that mixed up the offsets would open the wrong group's buffers.
- Disarming a group must restore plain direction-driven behaviour at once. A design that kept the stale enables would leave outputs floating.
- Random mixes of all writes, with random pad data, are compared against a model, so a mismatch between the per-buffer bit order and the line mapping shows up on line_val.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  localparam int GROUPS    = 2;
  localparam int BUFS      = 4;
  localparam int LINES     = 24;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 8;

  localparam logic [ADDR_W-1:0] OFF_TRI  = 4'hA;

  // buffer index inside a group
  localparam int BUF_CLO = 0;
  localparam int BUF_B   = 1;
  localparam int BUF_CHI = 2;
  localparam int BUF_A   = 3;

  function automatic logic [ADDR_W-1:0] mode_off(input int g);
    return (g == 0) ? 4'h3 : 4'h7;
  endfunction

  function automatic logic [ADDR_W-1:0] grp_off(input int g);
    return (g == 0) ? 4'h8 : 4'h9;
  endfunction

  function automatic logic [ADDR_W-1:0] sel_off(input int g);
    return (g == 0) ? 4'hC : 4'hD;
  endfunction

  // which buffer owns a given line of a group
  function automatic int line_owner(input int l);
    if (l < 8)       return BUF_A;
    else if (l < 16) return BUF_B;
    else if (l < 20) return BUF_CLO;
    else             return BUF_CHI;
  endfunction
endpackage

// File: rtl/pbc_regdec.sv
module pbc_regdec
  import pbc_pkg::*;
#(
  parameter int NG = GROUPS,
  parameter int AW = ADDR_W
) (
  input  logic          we,
  input  logic [AW-1:0] addr,
  output logic [NG-1:0] mode_wr,
  output logic [NG-1:0] grp_wr,
  output logic [NG-1:0] sel_wr,
  output logic          tri_wr
);
  for (genvar g = 0; g < NG; g++) begin : g_dec
    assign mode_wr[g] = we && (addr == mode_off(g));
    assign grp_wr[g]  = we && (addr == grp_off(g));
    assign sel_wr[g]  = we && (addr == sel_off(g));
  end
  assign tri_wr = we && (addr == OFF_TRI);
endmodule

// File: rtl/pbc_group.sv
module pbc_group
  import pbc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NB = BUFS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  logic          grp_wr,
  input  logic          sel_wr,
  input  logic [DW-1:0] wdata,
  input  logic          armed,
  output logic [NB-1:0] dir_in,
  output logic [NB-1:0] oe,
  output logic [NB-1:0] closed,
  output logic [NB-1:0] sel_q
);
  logic [NB-1:0] dir_q, dir_d;
  logic [NB-1:0] open_q, open_d;
  logic [NB-1:0] sel_d;
  logic          upd;
  logic          unused_bits;

  assign unused_bits = ^{wdata[6:5], wdata[2]};
  assign upd = mode_wr | grp_wr | sel_wr;

  always_comb begin
    dir_d  = dir_q;
    open_d = open_q;
    sel_d  = sel_q;
    if (mode_wr) begin
      dir_d[BUF_A]   = wdata[4];
      dir_d[BUF_CHI] = wdata[3];
      dir_d[BUF_B]   = wdata[1];
      dir_d[BUF_CLO] = wdata[0];
      open_d         = '0;
    end else if (grp_wr) begin
      open_d = wdata[7] ? '0 : '1;
    end else if (sel_wr) begin
      open_d = wdata[NB-1:0];
      sel_d  = wdata[NB-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      open_q <= '0;
      sel_q  <= '0;
    end else if (upd) begin
      dir_q  <= dir_d;
      open_q <= open_d;
      sel_q  <= sel_d;
    end
  end

  assign dir_in = dir_q;
  assign closed = armed ? ~open_q : '0;
  assign oe     = ~dir_q & ~closed;
endmodule

// File: rtl/pbc_line_mask.sv
module pbc_line_mask
  import pbc_pkg::*;
#(
  parameter int LN = LINES,
  parameter int NB = BUFS
) (
  input  logic [NB-1:0] closed,
  input  logic [LN-1:0] pad,
  output logic [LN-1:0] val
);
  for (genvar l = 0; l < LN; l++) begin : g_line
    assign val[l] = closed[line_owner(l)] ? 1'b1 : pad[l];
  end
endmodule

// File: rtl/pio_buf_ctrl.sv
module pio_buf_ctrl
  import pbc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NG = GROUPS,
  parameter int NB = BUFS,
  parameter int LN = LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NG*LN-1:0] pad_in,
  output logic [NG*NB-1:0] buf_dir_in,
  output logic [NG*NB-1:0] buf_oe,
  output logic [NG*LN-1:0] line_val
);
  logic [NG-1:0] mode_wr, grp_wr, sel_wr;
  logic          tri_wr;
  logic [NG-1:0] tri_q, tri_d;
  logic [NB-1:0] sel_q [NG];

  pbc_regdec #(.NG(NG), .AW(AW)) u_dec (
    .we(bus_we), .addr(bus_addr),
    .mode_wr(mode_wr), .grp_wr(grp_wr), .sel_wr(sel_wr), .tri_wr(tri_wr)
  );

  always_comb begin
    tri_d = tri_q;
    if (tri_wr) tri_d = bus_wdata[NG-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tri_q <= '0;
    else if (tri_wr) tri_q <= tri_d;
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [NB-1:0] closed;
    pbc_group #(.DW(DW), .NB(NB)) u_grp (
      .clk(clk), .rst_n(rst_n),
      .mode_wr(mode_wr[g]), .grp_wr(grp_wr[g]), .sel_wr(sel_wr[g]),
      .wdata(bus_wdata), .armed(tri_q[g]),
      .dir_in(buf_dir_in[g*NB +: NB]), .oe(buf_oe[g*NB +: NB]),
      .closed(closed), .sel_q(sel_q[g])
    );
    pbc_line_mask #(.LN(LN), .NB(NB)) u_mask (
      .closed(closed), .pad(pad_in[g*LN +: LN]), .val(line_val[g*LN +: LN])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFF_TRI) bus_rdata[NG-1:0] = tri_q;
    for (int g = 0; g < NG; g++) begin
      if (bus_addr == sel_off(g)) bus_rdata[NB-1:0] = sel_q[g];
    end
  end
endmodule

// File: rtl/pio_buf_ctrl_chk.sv
module pio_buf_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [3:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic [1:0]  tri_q,
  input logic [7:0]  buf_dir_in,
  input logic [7:0]  buf_oe,
  input logic [47:0] line_val
);
  // R1
  mode_dir_g0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'h3) |=> buf_dir_in[3:0] ==
      {$past(bus_wdata[4]), $past(bus_wdata[3]), $past(bus_wdata[1]), $past(bus_wdata[0])});

  // R4
  unarmed_g0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tri_q[0] |-> buf_oe[3:0] == ~buf_dir_in[3:0]);

  // R4
  unarmed_g1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tri_q[1] |-> buf_oe[7:4] == ~buf_dir_in[7:4]);

  // R5
  mode_closes_g0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'h3 && tri_q[0]) |=> buf_oe[3:0] == 4'b0);

  // R6
  grp_close_g1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'h9 && bus_wdata[7]) |=>
      ($stable(buf_dir_in[7:4]) && (!tri_q[1] || buf_oe[7:4] == 4'b0)));

  // R8
  input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_dir_in & buf_oe) == 8'b0);

  // R9
  closed_high_g0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_q[0] && buf_dir_in[3:0] == 4'b0 && buf_oe[3:0] == 4'b0) |->
      line_val[23:0] == 24'hFFFFFF);
endmodule

bind pio_buf_ctrl pio_buf_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .tri_q(tri_q), .buf_dir_in(buf_dir_in),
  .buf_oe(buf_oe), .line_val(line_val)
);

// File: tb/pio_buf_ctrl_tb_top.sv
module pio_buf_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [47:0] pad_in;
  logic [7:0]  buf_dir_in;
  logic [7:0]  buf_oe;
  logic [47:0] line_val;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [1:0] m_tri;
  logic [3:0] m_dir  [2];
  logic [3:0] m_open [2];
  logic [3:0] m_sel  [2];

  always #4 clk = ~clk;

  pio_buf_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .buf_dir_in(buf_dir_in), .buf_oe(buf_oe), .line_val(line_val)
  );

  function automatic logic [7:0] exp_dir();
    return {m_dir[1], m_dir[0]};
  endfunction

  function automatic logic [3:0] closed_of(input int g);
    return m_tri[g] ? ~m_open[g] : 4'b0;
  endfunction

  function automatic logic [7:0] exp_oe();
    return {~m_dir[1] & ~closed_of(1), ~m_dir[0] & ~closed_of(0)};
  endfunction

  function automatic logic [47:0] exp_line(input logic [47:0] pad);
    logic [47:0] r;
    for (int g = 0; g < 2; g++) begin
      logic [3:0] c;
      c = closed_of(g);
      for (int l = 0; l < 24; l++) begin
        int b;
        b = (l < 8) ? 3 : (l < 16) ? 1 : (l < 20) ? 0 : 2;
        r[g*24+l] = c[b] ? 1'b1 : pad[g*24+l];
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    case (a)
      4'hA: return {6'b0, m_tri};
      4'hC: return {4'b0, m_sel[0]};
      4'hD: return {4'b0, m_sel[1]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_wr(input logic [3:0] a, input logic [7:0] d);
    int g;
    case (a)
      4'h3, 4'h7: begin
        g = (a == 4'h7) ? 1 : 0;
        m_dir[g]  = {d[4], d[3], d[1], d[0]};
        m_open[g] = 4'b0;
      end
      4'h8, 4'h9: begin
        g = (a == 4'h9) ? 1 : 0;
        m_open[g] = d[7] ? 4'b0000 : 4'b1111;
      end
      4'hC, 4'hD: begin
        g = (a == 4'hD) ? 1 : 0;
        m_open[g] = d[3:0];
        m_sel[g]  = d[3:0];
      end
      4'hA: m_tri = d[1:0];
      default: ;
    endcase
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    pad_in = {$urandom, $urandom};
    @(negedge clk);
    bus_we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic check_outs(input string tag);
    chk({tag, " R1 dir"}, 64'(buf_dir_in), 64'(exp_dir()));
    chk({tag, " R4/R5/R6/R7/R8 oe"}, 64'(buf_oe), 64'(exp_oe()));
    chk({tag, " R9 lines"}, 64'(line_val), 64'(exp_line(pad_in)));
  endtask

  task automatic rd(input string tag, input logic [3:0] a);
    bus_addr = a;
    #1;
    chk(tag, 64'(bus_rdata), 64'(exp_rd(a)));
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog timeout");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 4'h0; bus_wdata = 8'h00;
    pad_in = 48'h1234_5678_9ABC;
    m_tri = 2'b00;
    for (int g = 0; g < 2; g++) begin
      m_dir[g] = 4'hF; m_open[g] = 4'h0; m_sel[g] = 4'h0;
    end
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 reset dir", 64'(buf_dir_in), 64'hFF);
    chk("R2 reset oe", 64'(buf_oe), 64'h00);
    rd("R2 reset arm readback", 4'hA);
    rd("R2 reset sel0 readback", 4'hC);
    rd("R2 reset sel1 readback", 4'hD);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 example word: A in, C hi in, B out, C lo out
    wr(4'h3, 8'h98);
    chk("R1 0x98 dir g0", 64'(buf_dir_in[3:0]), 64'b1100);
    // R4 unarmed: outputs drive, group close ignored
    wr(4'h8, 8'h80);
    chk("R4 unarmed group close ignored", 64'(buf_oe[3:0]), 64'b0011);
    // R3 arm group 0
    wr(4'hA, 8'h01);
    rd("R3 arm readback", 4'hA);
    chk("R5 armed after mode word closed", 64'(buf_oe[3:0]), 64'b0000);
    chk("R9 closed lines high", 64'(line_val[23:0]), 64'hFFFFFF);
    // R6 open group 0, g1 untouched
    wr(4'h8, 8'h00);
    chk("R6 open group0", 64'(buf_oe[3:0]), 64'b0011);
    chk("R6 group1 untouched", 64'(buf_oe[7:4]), 64'b0000);
    // R5 mode word with bit 7 clear still closes
    wr(4'h3, 8'h00);
    chk("R5 mode word bit7 low closes", 64'(buf_oe[3:0]), 64'b0000);
    // R7 selective: open only port B (bit1)
    wr(4'hC, 8'h02);
    chk("R7 selective B only", 64'(buf_oe[3:0]), 64'b0010);
    rd("R7 sel0 readback", 4'hC);
    check_outs("R9 selective lines");
    // R6 close keeps direction
    wr(4'h8, 8'h80);
    chk("R6 close keeps dir", 64'(buf_dir_in[3:0]), 64'b0000);
    chk("R6 close all", 64'(buf_oe[3:0]), 64'b0000);
    // R10 unused offsets
    wr(4'h0, 8'hFF); wr(4'hF, 8'h00); wr(4'hB, 8'h55);
    check_outs("R10 unused writes");
    rd("R10 unused read 0x0", 4'h0);
    rd("R10 unused read 0xB", 4'hB);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] a;
      logic [7:0] d;
      int pick;
      pick = $urandom_range(0, 8);
      case (pick)
        0: a = 4'h3; 1: a = 4'h7; 2: a = 4'h8; 3: a = 4'h9;
        4: a = 4'hA; 5: a = 4'hC; 6: a = 4'hD;
        7: a = 4'h0; default: a = 4'(4'hE + $urandom_range(0, 1));
      endcase
      d = 8'($urandom);
      wr(a, d);
      check_outs("rand");
      rd("R3 rand arm readback", 4'hA);
      rd("R7 rand sel readback", (i % 2 == 0) ? 4'hC : 4'hD);
      rd("R10 rand unused read", 4'h5);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule